// File: doc/BRIEF.md
# Three-Source Glitch-Free Test Clock Switch

This block picks the clock that drives a logic region under test: the functional clock, a slow scan-shift clock or a self-test (BIST) clock. Raw test controls are decoded into a one-hot source request. The chosen clock reaches the output through a per-source enable. A changeover never produces a runt pulse or a doubled edge.

Each source owns a short synchronizer chain clocked on the falling edge of that source. A chain passes its request only while every other source's enable reads low. The outgoing clock is therefore frozen low at a safe point before the incoming one is released. The same decode also drives a flag that blocks the functional asynchronous reset in any test mode, and a select that steers the scan-in data path during shift. test_mode and bist_enable are static for a whole test. scan_enable may flip between shift and capture many times, and every flip is a full stop-switch-start handover.

Top module: `tclk_switch`

## Requirements
- R1: With test_mode and bist_enable both high, the BIST clock is requested and, once the handover ends, clk_out follows clk_bist.
- R2: With test_mode and scan_enable high and bist_enable low, the shift clock is requested and clk_out then follows clk_shift.
- R3: In every other input combination (functional operation, or capture with scan_enable low), the functional clock is requested and clk_out then follows clk_func.
- R4: A handover stops the old clock on its own falling edge before the new one is enabled on the new clock's falling edge. No high or low pulse on clk_out is ever shorter than half the fastest source period.
- R5: At most one source enable is high at any time. A source enable rises only after all other enables have been seen low through its synchronizer.
- R6: rst_gate equals test_mode, so it is high in every test mode and low in functional operation.
- R7: scan_sel is high only when test_mode and scan_enable are high and bist_enable is low. Otherwise it is low.
- R8: Repeated scan_enable toggles between shift and capture each complete a clean handover with the correct final clock.
- R9: While rst is high, the shift and BIST enables clear and the functional enable fills. After reset, clk_out follows clk_func and switch_busy is low.
- R10: switch_busy rises as soon as the requested source differs from the enabled one. It stays high until the new source's enable is asserted, and it stays low when the request does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_func | input | 1 | Functional clock source |
| clk_shift | input | 1 | Slow scan-shift clock source |
| clk_bist | input | 1 | Self-test clock source |
| rst | input | 1 | Active-high reset, sampled on each source's falling edge |
| test_mode | input | 1 | Static test mode control |
| bist_enable | input | 1 | Static self-test select |
| scan_enable | input | 1 | Dynamic shift/capture control |
| clk_out | output | 1 | Selected, glitch-free clock |
| rst_gate | output | 1 | High to block the functional asynchronous reset |
| scan_sel | output | 1 | High to route scan-in data instead of functional data |
| switch_busy | output | 1 | High while a source changeover is in progress |

## Verification
The hardest case to reach is a handover where the outgoing clock is partway through a high phase while the incoming clock sits at an unrelated phase. That is where a runt or an overlap would show. The stimulus runs the three sources at non-harmonic periods with distinct start offsets, and it changes the controls at varied moments, including repeated scan_enable flips. Each changeover therefore lands at a different phase relation. A monitor times every high and low phase of clk_out over the whole run. After each handover it identifies the active source from the measured high-phase width.

// File: rtl/tclk_pkg.sv
`timescale 1ns/1ps
package tclk_pkg;
  localparam int NSRC = 3;

  // Bit positions in the one-hot request and enable vectors
  typedef enum int unsigned {
    SRC_FUNC  = 0,
    SRC_SHIFT = 1,
    SRC_BIST  = 2
  } src_e;
endpackage

// File: rtl/tclk_mode_decode.sv
`timescale 1ns/1ps
module tclk_mode_decode
  import tclk_pkg::*;
(
  input  logic            test_mode,
  input  logic            bist_enable,
  input  logic            scan_enable,
  output logic [NSRC-1:0] req,
  output logic            rst_gate,
  output logic            scan_sel
);
  logic want_bist;
  logic want_shift;

  always_comb begin
    want_bist  = test_mode & bist_enable;
    want_shift = test_mode & scan_enable & ~bist_enable;
    req             = '0;
    req[SRC_BIST]   = want_bist;
    req[SRC_SHIFT]  = want_shift;
    req[SRC_FUNC]   = ~(want_bist | want_shift);
    rst_gate        = test_mode;
    scan_sel        = want_shift;
  end

  // Guards on the decode outputs
  always_comb begin
    a_r5_req_onehot: assert ($onehot(req));
    a_r7_scan_sel_shift: assert (!scan_sel || req[SRC_SHIFT]);
    a_r6_gate_in_test: assert (req[SRC_FUNC] || rst_gate);
  end
endmodule

// File: rtl/tclk_src_gate.sv
`timescale 1ns/1ps
module tclk_src_gate #(
  parameter int STAGES     = 2,
  parameter bit IS_DEFAULT = 1'b0
) (
  input  logic clk_src,
  input  logic rst,
  input  logic req,
  input  logic others_off,
  output logic en
);
  logic [STAGES-1:0] sync_q;
  logic              d;

  // During reset only the default source keeps asking; all paths wait for others
  always_comb d = (rst ? IS_DEFAULT : req) & others_off;

  always_ff @(negedge clk_src) begin
    if (rst && !IS_DEFAULT) sync_q <= '0;
    else                    sync_q <= {sync_q[STAGES-2:0], d};
  end

  always_comb en = sync_q[STAGES-1];

  // Exclusive ownership of the output while enabled
  a_r5_exclusive: assert property (@(negedge clk_src) disable iff (rst)
    en |-> others_off);

  // Start only once all other sources were seen stopped
  a_r4_start_after_stop: assert property (@(negedge clk_src) disable iff (rst)
    $rose(en) |-> $past(others_off, STAGES-1));

  // Release only when the request went away or another source held the output
  a_r4_release_cause: assert property (@(negedge clk_src) disable iff (rst)
    $fell(en) |-> $past(!req || !others_off, STAGES-1));
endmodule

// File: rtl/tclk_clk_combine.sv
`timescale 1ns/1ps
module tclk_clk_combine #(
  parameter int N = 3
) (
  input  logic [N-1:0] clk_vec,
  input  logic [N-1:0] en,
  output logic         clk_out
);
  // Each enable moves only while its own clock is low
  always_comb clk_out = |(clk_vec & en);
endmodule

// File: rtl/tclk_switch.sv
`timescale 1ns/1ps
module tclk_switch
  import tclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_func,
  input  logic clk_shift,
  input  logic clk_bist,
  input  logic rst,
  input  logic test_mode,
  input  logic bist_enable,
  input  logic scan_enable,
  output logic clk_out,
  output logic rst_gate,
  output logic scan_sel,
  output logic switch_busy
);
  localparam int STG = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [NSRC-1:0] clk_vec;
  logic [NSRC-1:0] req;
  logic [NSRC-1:0] en;

  always_comb begin
    clk_vec             = '0;
    clk_vec[SRC_FUNC]   = clk_func;
    clk_vec[SRC_SHIFT]  = clk_shift;
    clk_vec[SRC_BIST]   = clk_bist;
  end

  tclk_mode_decode u_decode (
    .test_mode   (test_mode),
    .bist_enable (bist_enable),
    .scan_enable (scan_enable),
    .req         (req),
    .rst_gate    (rst_gate),
    .scan_sel    (scan_sel)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic others_off;
    always_comb others_off = ~|(en & ~(NSRC'(1) << i));

    tclk_src_gate #(
      .STAGES     (STG),
      .IS_DEFAULT (i == int'(SRC_FUNC))
    ) u_gate (
      .clk_src    (clk_vec[i]),
      .rst        (rst),
      .req        (req[i]),
      .others_off (others_off),
      .en         (en[i])
    );
  end

  tclk_clk_combine #(.N(NSRC)) u_combine (
    .clk_vec (clk_vec),
    .en      (en),
    .clk_out (clk_out)
  );

  // Busy while the requested source does not yet own the output
  always_comb switch_busy = |(req & ~en);
endmodule

// File: tb/tclk_switch_bench.sv
`timescale 1ns/1ps
module tclk_switch_bench;
  logic clk_func = 1'b0, clk_shift = 1'b0, clk_bist = 1'b0;
  logic rst = 1'b1;
  logic test_mode = 1'b0, bist_enable = 1'b0, scan_enable = 1'b0;
  logic clk_out, rst_gate, scan_sel, switch_busy;

  tclk_switch u_tclk_switch (
    .clk_func    (clk_func),
    .clk_shift   (clk_shift),
    .clk_bist    (clk_bist),
    .rst         (rst),
    .test_mode   (test_mode),
    .bist_enable (bist_enable),
    .scan_enable (scan_enable),
    .clk_out     (clk_out),
    .rst_gate    (rst_gate),
    .scan_sel    (scan_sel),
    .switch_busy (switch_busy)
  );

  // 125 MHz functional clock; others non-harmonic with offsets
  localparam real HALF_FUNC  = 4.0;
  localparam real HALF_SHIFT = 20.0;
  localparam real HALF_BIST  = 5.5;
  localparam real MIN_PULSE  = 4.0;

  initial forever #(HALF_FUNC) clk_func = ~clk_func;
  initial begin #1.3; forever #(HALF_SHIFT) clk_shift = ~clk_shift; end
  initial begin #0.7; forever #(HALF_BIST) clk_bist = ~clk_bist; end

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // Scoreboard
  typedef struct {
    int    src;
    bit    rg;
    bit    ss;
    string rq;
  } exp_t;
  exp_t exp_q[$];
  int   pushed   = 0;
  int   done_cnt = 0;
  int   cur_src  = 0;

  function automatic int classify(input real w);
    if (w > 3.7 && w < 4.3)   return 0;
    if (w > 19.7 && w < 20.3) return 1;
    if (w > 5.2 && w < 5.8)   return 2;
    return 9;
  endfunction

  function automatic string src_req(input int s);
    if (s == 2) return "R1";
    if (s == 1) return "R2";
    return "R3";
  endfunction

  // Monitor: pops expectations and compares once the handover settles
  initial begin
    forever begin
      exp_t e;
      real  t0, w;
      wait (exp_q.size() > 0);
      e = exp_q.pop_front();
      wait (switch_busy == 1'b0);
      @(posedge clk_out); t0 = $realtime;
      @(negedge clk_out); w = $realtime - t0;
      chk(classify(w) == e.src, e.rq, "active source by high width",
          classify(w), e.src);
      chk(rst_gate == e.rg, "R6", "rst_gate", int'(rst_gate), int'(e.rg));
      chk(scan_sel == e.ss, "R7", "scan_sel", int'(scan_sel), int'(e.ss));
      chk(switch_busy == 1'b0, "R10", "busy after handover",
          int'(switch_busy), 0);
      done_cnt++;
    end
  end

  // Pulse-width monitor over the whole run after reset (R4, R5)
  bit  mon_on = 1'b0;
  real last_edge = 0.0;
  int  runts = 0;
  always @(clk_out) begin
    real w;
    w = $realtime - last_edge;
    if (mon_on && w < MIN_PULSE - 0.01) begin
      runts++;
      n_checks++;
      n_fail++;
      $display("FAIL R4 short pulse at %0t: actual=%0d ps expected>=%0d ps",
               $realtime, int'(w * 1000.0), int'(MIN_PULSE * 1000.0));
    end
    last_edge = $realtime;
  end

  // Driver
  task automatic step(input logic tm, input logic be, input logic se,
                      input int exp_src, input string rq);
    exp_t e;
    bit   change;
    change = (exp_src != cur_src);
    #3.1;
    test_mode   = tm;
    bist_enable = be;
    scan_enable = se;
    #1;
    chk(switch_busy == change, "R10", "busy right after control change",
        int'(switch_busy), int'(change));
    e.src = exp_src;
    e.rg  = tm;
    e.ss  = tm & se & ~be;
    e.rq  = rq;
    exp_q.push_back(e);
    pushed++;
    wait (done_cnt == pushed);
    cur_src = exp_src;
  endtask

  initial begin
    real t0, w;
    // R9: reset fills the functional enable
    repeat (30) @(posedge clk_func);
    #1;
    chk(switch_busy == 1'b0, "R9", "busy in reset after fill", int'(switch_busy), 0);
    chk(rst_gate == 1'b0, "R6", "rst_gate in functional", int'(rst_gate), 0);
    chk(scan_sel == 1'b0, "R7", "scan_sel in functional", int'(scan_sel), 0);
    @(posedge clk_out); t0 = $realtime;
    @(negedge clk_out); w = $realtime - t0;
    chk(classify(w) == 0, "R9", "functional clock after reset", classify(w), 0);
    rst = 1'b0;
    repeat (4) @(posedge clk_func);
    mon_on = 1'b1;

    step(1'b0, 1'b0, 1'b0, 0, "R3");
    step(1'b1, 1'b0, 1'b0, 0, "R3");   // capture
    step(1'b1, 1'b0, 1'b1, 1, "R2");   // shift
    step(1'b1, 1'b0, 1'b0, 0, "R3");
    step(1'b1, 1'b0, 1'b1, 1, "R2");
    step(1'b1, 1'b1, 1'b1, 2, "R1");   // BIST wins over scan_enable
    step(1'b1, 1'b1, 1'b0, 2, "R1");
    step(1'b0, 1'b1, 1'b0, 0, "R3");   // bist_enable ignored outside test
    step(1'b1, 1'b1, 1'b0, 2, "R1");
    step(1'b1, 1'b0, 1'b1, 1, "R2");
    step(1'b0, 1'b0, 1'b1, 0, "R3");   // scan_enable ignored outside test
    // R8: repeated shift/capture flips at drifting phases
    for (int k = 0; k < 6; k++) begin
      #(1.7 * k);
      step(1'b1, 1'b0, 1'b1, 1, "R8");
      #(2.3 * k);
      step(1'b1, 1'b0, 1'b0, 0, "R8");
    end
    step(1'b0, 1'b0, 1'b0, 0, "R3");

    chk(runts == 0, "R5", "runt or overlap seen on clk_out", runts, 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  // Watchdog
  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R4 watchdog: actual=%0d expected=%0d", done_cnt, pushed);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule